// File: doc/BRIEF.md
# DRAM Prefetch Burst Serializer

This block turns one column read into a short burst of narrow beats. The memory core is slow and wide. On a single read strobe it returns a prefetch word that holds several neighbouring datawords from the open row. The block captures that word in one core cycle. It then sends the datawords out one per fast-clock cycle on a narrow IO bus, and no further column address is needed.

The burst depth is a parameter and may be 2, 4 or 8. It fixes the number of beats per request, the width of the prefetch word (depth times IO width) and the IO-to-core rate ratio. The block aligns the requested column down to a multiple of the depth and hands that column to the core. It presents beats in ascending column order and marks each beat with its column. A ready output holds off new requests while a burst drains. Ready rises again on the final beat, so a request accepted then follows with no idle beat.

Top module: `prefetch_serializer`

## Requirements
- R1: `fetch_col_o` equals `col_i` with its low log2(DEPTH) bits forced to zero, combinationally, in every cycle.
- R2: A request is accepted when `rd_i` and `ready_o` are both high at a rising clock edge. If no further request is accepted, `valid_o` is high for exactly DEPTH consecutive cycles, starting in the cycle after acceptance, and is low afterwards.
- R3: Beat k of a burst (k = 0 is the first) carries `core_data_i[k*IO_W +: IO_W]`, as sampled at the acceptance edge. During that beat, `beat_col_o` equals the aligned column plus k, so columns ascend.
- R4: `last_o` is high only on beat DEPTH-1 of a burst, and on that beat the low log2(DEPTH) bits of `beat_col_o` are all ones.
- R5: `ready_o` is low on every beat of a burst except the last. A request presented while `ready_o` is low is ignored: the data and columns of the running burst do not change, and no extra beats appear.
- R6: A request accepted on the final beat starts the next burst in the next cycle, with no idle cycle between the bursts. Sustained throughput is one request every DEPTH cycles.
- R7: While `rst_ni` is low, and until the first request after reset, `valid_o` and `last_o` are low, `ready_o` is high and `data_o` is zero.
- R8: `data_o` is zero in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast IO-beat clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Column read strobe |
| col_i | input | COL_W | Requested column |
| ready_o | output | 1 | Request can be accepted this cycle |
| fetch_col_o | output | COL_W | Aligned column sent to the core |
| core_data_i | input | DEPTH*IO_W | Prefetch word, lowest column in the low bits |
| data_o | output | IO_W | Beat data |
| valid_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of the burst |
| beat_col_o | output | COL_W | Column of the current beat |

## Verification
The bench sweeps every column value. This catches alignment mistakes that would send an unaligned column to the core or scramble the beat order, for example a burst that starts mid-group or ends on the wrong column. It runs back-to-back bursts with the strobe held high. A design that drops the ready handshake on the last beat would show an idle gap, and one that accepts too early would cut bursts short. Requests made mid-burst carry junk data so that any leak into the shift register shows up. The bench also checks that data outside a burst reads zero.

// File: rtl/prefetch_pkg.sv
package prefetch_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BURST = 1'b1} burst_state_e;

  function automatic bit depth_ok(int d);
    return (d == 2) || (d == 4) || (d == 8);
  endfunction
endpackage

// File: rtl/prefetch_ctrl.sv
module prefetch_ctrl
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int COL_W = 8,
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [COL_W-1:0] base_col_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             ready_o,
  output logic [COL_W-1:0] beat_col_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH - 1);

  burst_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] base_q;

  assign valid_o    = (state_q == ST_BURST);
  assign last_o     = valid_o && (cnt_q == CNT_MAX);
  assign ready_o    = !valid_o || last_o;
  assign load_o     = req_i && ready_o;
  assign shift_o    = valid_o && !load_o;
  assign beat_col_o = base_q | COL_W'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
    end else if (load_o) begin
      state_q <= ST_BURST;
      cnt_q   <= '0;
      base_q  <= base_col_i;
    end else if (last_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (valid_o) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // burst stays up until the final beat
  assert_burst_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);

  assert_col_ascend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> (beat_col_o == $past(beat_col_o) + COL_W'(1)));

  assert_last_col_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (&beat_col_o[CNT_W-1:0]));

  assert_gapless_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && req_i) |=> (valid_o && beat_col_o[CNT_W-1:0] == '0));
endmodule

// File: rtl/prefetch_shreg.sv
module prefetch_shreg #(
  parameter int DEPTH = 4,
  parameter int IO_W  = 8,
  localparam int WORD_W = DEPTH * IO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [IO_W-1:0]   head_o
);
  logic [IO_W-1:0] lane_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    logic [IO_W-1:0] next_in;
    if (g == DEPTH - 1) begin : g_top
      assign next_in = '0;
    end else begin : g_mid
      assign next_in = lane_q[g+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q[g] <= '0;
      else if (load_i)  lane_q[g] <= word_i[g*IO_W +: IO_W];
      else if (shift_i) lane_q[g] <= next_in;
    end
  end

  assign head_o = lane_q[0];

  assert_load_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (head_o == $past(word_i[IO_W-1:0])));
endmodule

// File: rtl/prefetch_serializer.sv
module prefetch_serializer
  import prefetch_pkg::*;
#(
  parameter int IO_W  = 8,
  parameter int DEPTH = 4,
  parameter int COL_W = 8,
  localparam int WORD_W = DEPTH * IO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              ready_o,
  output logic [COL_W-1:0]  fetch_col_o,
  input  logic [WORD_W-1:0] core_data_i,
  output logic [IO_W-1:0]   data_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [COL_W-1:0]  beat_col_o
);
  localparam logic [COL_W-1:0] ALIGN_MASK = ~COL_W'(DEPTH - 1);

  logic            load, shift;
  logic [IO_W-1:0] head;

  initial assert (depth_ok(DEPTH)) else $error("DEPTH must be 2, 4 or 8");

  assign fetch_col_o = col_i & ALIGN_MASK;

  prefetch_ctrl #(.DEPTH(DEPTH), .COL_W(COL_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (rd_i),
    .base_col_i (fetch_col_o),
    .load_o     (load),
    .shift_o    (shift),
    .valid_o    (valid_o),
    .last_o     (last_o),
    .ready_o    (ready_o),
    .beat_col_o (beat_col_o)
  );

  prefetch_shreg #(.DEPTH(DEPTH), .IO_W(IO_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .word_i  (core_data_i),
    .head_o  (head)
  );

  assign data_o = valid_o ? head : '0;

  assert_hold_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> valid_o);

  assert_accept_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ready_o) |=> (valid_o && beat_col_o == $past(fetch_col_o)));
endmodule

// File: tb/sim_prefetch_serializer.sv
module sim_prefetch_serializer;
  localparam int IO_W  = 8;
  localparam int DEPTH = 4;
  localparam int COL_W = 6;
  localparam int WORD_W = DEPTH * IO_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_i = 1'b0;
  logic [COL_W-1:0]  col_i = '0;
  logic [WORD_W-1:0] core_data_i = '0;
  logic              ready_o, valid_o, last_o;
  logic [COL_W-1:0]  fetch_col_o, beat_col_o;
  logic [IO_W-1:0]   data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prefetch_serializer #(.IO_W(IO_W), .DEPTH(DEPTH), .COL_W(COL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .col_i(col_i),
    .ready_o(ready_o), .fetch_col_o(fetch_col_o), .core_data_i(core_data_i),
    .data_o(data_o), .valid_o(valid_o), .last_o(last_o), .beat_col_o(beat_col_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [COL_W-1:0] align(logic [COL_W-1:0] c);
    return c & ~COL_W'(DEPTH - 1);
  endfunction

  // column-dependent pattern per lane
  function automatic logic [WORD_W-1:0] mkword(logic [COL_W-1:0] base, int salt);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < DEPTH; k++)
      w[k*IO_W +: IO_W] = IO_W'((int'(base) + k) * 7 + salt) ^ 8'h5A;
    return w;
  endfunction

  // one burst observed at negedges; data latched in 'w', base in 'b'
  task automatic check_beats(logic [COL_W-1:0] b, logic [WORD_W-1:0] w,
                             bit chain, logic [COL_W-1:0] nxt_col,
                             logic [WORD_W-1:0] nxt_w, bit junk);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R2 valid", valid_o, 1);
      chk("R3 data", data_o, w[k*IO_W +: IO_W]);
      chk("R3 col", beat_col_o, b + COL_W'(k));
      chk("R4 last", last_o, (k == DEPTH - 1));
      chk("R5 ready", ready_o, (k == DEPTH - 1));
      if (k == DEPTH - 1) begin
        rd_i = chain; col_i = nxt_col; core_data_i = nxt_w;
      end else if (junk) begin
        rd_i = 1'b1; col_i = ~b; core_data_i = ~w;
      end else begin
        rd_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 valid", valid_o, 0);
    chk("R7 last", last_o, 0);
    chk("R7 ready", ready_o, 1);
    chk("R7 data", data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 valid post", valid_o, 0);
    chk("R8 idle data", data_o, 0);

    // isolated requests over every column, junk requests mid-burst
    for (int c = 0; c < (1 << COL_W); c++) begin
      logic [COL_W-1:0] cc = COL_W'(c);
      logic [WORD_W-1:0] w = mkword(align(cc), c);
      rd_i = 1'b1; col_i = cc; core_data_i = w;
      #1;
      chk("R1 fetch col", fetch_col_o, align(cc));
      chk("R7 ready idle", ready_o, 1);
      @(negedge clk);
      check_beats(align(cc), w, 1'b0, '0, '0, (c % 2) == 1);
      chk("R2 valid end", valid_o, 0);
      chk("R8 data idle", data_o, 0);
      chk("R4 last end", last_o, 0);
    end

    // back-to-back bursts with strobe held high (R6)
    begin
      logic [COL_W-1:0] cc = COL_W'(5);
      logic [WORD_W-1:0] w = mkword(align(cc), 99);
      rd_i = 1'b1; col_i = cc; core_data_i = w;
      @(negedge clk);
      for (int n = 0; n < 16; n++) begin
        logic [COL_W-1:0] nc = COL_W'(n * 11 + 3);
        logic [WORD_W-1:0] nw = mkword(align(nc), n);
        check_beats(align(cc), w, 1'b1, nc, nw, 1'b1);
        chk("R6 no gap", valid_o, 1);
        cc = nc; w = nw;
      end
      check_beats(align(cc), w, 1'b0, '0, '0, 1'b0);
      chk("R6 final idle", valid_o, 0);
    end

    // reset mid-burst
    rd_i = 1'b1; col_i = 6'd9; core_data_i = mkword(6'd8, 1);
    @(negedge clk);
    rd_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R7 async valid", valid_o, 0);
    chk("R7 async data", data_o, 0);
    chk("R7 async ready", ready_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule